// File: doc/BRIEF.md
# Serial Receive Engine with Break Detection

This block turns an asynchronous serial receive line into characters for a receive FIFO. It samples the line once per pulse of an oversampling enable running at sixteen times the bit rate. It assembles characters of five to eight data bits, with or without a parity bit, and hands each character over as a single-cycle valid pulse. The data byte travels with three flags: framing error, parity error and break. Character length and parity mode are static configuration inputs. A baud-rate generator outside the block supplies the oversampling enable.

A line held at space for a whole character, including its parity bit and its stop bit, is a break. The block reports a break once, as a zero byte with the break flag set. It then accepts no further characters until the line has been marking for half a bit time. A separate pulse output marks both the start and the end of a break, so it can feed a change-of-break interrupt. In wake-up mode the parity flag carries the received address/data bit instead of a parity check result.

The controller has six states. ST_IDLE waits for the line to go low. ST_START qualifies the start bit at mid-bit: a high sample returns to ST_IDLE, a low sample goes to ST_DATA. ST_DATA samples one data bit per bit cell and leaves after the last bit, to ST_PAR when parity is enabled and to ST_STOP otherwise. ST_PAR samples the parity bit and goes to ST_STOP. ST_STOP samples the stop bit and delivers the character. It then goes to ST_BRK on a break and to ST_IDLE otherwise. ST_BRK waits for eight consecutive high samples and then returns to ST_IDLE.

Top module: `uart_brk_rx`

## Requirements
- R1: While reset is asserted and after it is released, rx_valid, brk_chg, rx_data and all flags are zero, and an idle (high) line delivers no character.
- R2: A low on the line is accepted as a start bit only if it is still low on the 8th oversampling tick after the first low sample; a shorter low pulse delivers nothing.
- R3: cfg_len selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3). Bits are received LSB first, each sampled at the centre of its cell, and the rx_data bits above the length are zero.
- R4: cfg_par selects the parity mode: 0 none, 1 even, 2 odd, 3 forced to 0, 4 forced to 1, 5 wake-up. In modes 1 to 4 a parity bit follows the data, and rx_perr is 1 exactly when that bit differs from the expected value. In mode 0 there is no parity bit and rx_perr is 0.
- R5: In mode 5 a ninth bit position follows the data and rx_perr carries its received value, with no check.
- R6: A stop bit sampled low on a character whose data bits or parity bit are not all zero sets rx_ferr, delivers the received data and clears rx_brk.
- R7: A character whose data bits and parity bit (when present) are all zero and whose stop bit is low is delivered once, as rx_data 0 with rx_brk 1 and rx_ferr 0 and rx_perr 0.
- R8: After a break no character is delivered until the line has been high for 8 consecutive oversampling ticks. A shorter high pulse restarts that count.
- R9: brk_chg pulses for one cycle in the same cycle as the break character and again when the end of the break is detected, and at no other time.
- R10: A break that begins inside a character makes that character a framing error. It is reported as a break only if the line stays low through the whole of the following character.
- R11: rx_valid is a single-cycle pulse, and rx_ferr, rx_perr and rx_brk are zero whenever rx_valid is zero.
- R12: All timing is counted in tick16 pulses. Clock cycles without tick16 do not advance the receiver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Asynchronous serial receive line, high when idle |
| cfg_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| cfg_par | input | 3 | Parity mode: 0 none, 1 even, 2 odd, 3 force 0, 4 force 1, 5 wake-up |
| rx_valid | output | 1 | One-cycle pulse: a character is delivered |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ferr | output | 1 | Framing error flag for this character |
| rx_perr | output | 1 | Parity error, or the address/data bit in wake-up mode |
| rx_brk | output | 1 | Character is a break |
| brk_chg | output | 1 | One-cycle pulse at break start and at break end |

## Verification
A bit counter or tick counter that is off by one moves every sampling point by a bit. The next character then shows at the ports as shifted data or a spurious framing error, at the moment of its stop sample. If the controller stays stuck in the break state, the bench sees no brk_chg end pulse and the next frame is lost, one character time after the line returns high. If the controller leaves the break state too early, a short high glitch yields an extra delivered character within one character time. The sweeps cover every length and parity mode, and both correct and flipped parity, so an error in the parity path shows on rx_perr of the first affected frame.

// File: rtl/uart_brk_rx_pkg.sv
`timescale 1ns/1ps
package uart_brk_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_BRK   = 3'd5
    } rx_state_e;

    typedef enum logic [2:0] {
        PM_NONE   = 3'd0,
        PM_EVEN   = 3'd1,
        PM_ODD    = 3'd2,
        PM_FORCE0 = 3'd3,
        PM_FORCE1 = 3'd4,
        PM_WAKE   = 3'd5
    } par_mode_e;

    // True when a bit position follows the data bits.
    function automatic logic par_slot(input logic [2:0] mode);
        return (mode >= PM_EVEN) && (mode <= PM_WAKE);
    endfunction

endpackage

// File: rtl/uart_brk_rx_sync.sv
`timescale 1ns/1ps
module uart_brk_rx_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= {STAGES{IDLE_LVL}};
        end else begin
            sr_q <= {sr_q[STAGES-2:0], d};
        end
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/uart_brk_rx_parchk.sv
`timescale 1ns/1ps
module uart_brk_rx_parchk
    import uart_brk_rx_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NB_W = 4
) (
    input  logic [DW-1:0]   data,
    input  logic [NB_W-1:0] nbits,
    input  logic [2:0]      mode,
    input  logic            pbit,
    output logic            flag
);
    logic [DW-1:0] mask;
    logic          odd_ones;

    // Mask off bit positions above the programmed length.
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < int'(nbits));
        end
    end

    assign odd_ones = ^(data & mask);

    always_comb begin
        unique case (mode)
            PM_EVEN:   flag = (pbit != odd_ones);
            PM_ODD:    flag = (pbit == odd_ones);
            PM_FORCE0: flag = pbit;
            PM_FORCE1: flag = !pbit;
            PM_WAKE:   flag = pbit;
            default:   flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_brk_rx.sv
`timescale 1ns/1ps
module uart_brk_rx
    import uart_brk_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DW          = 8,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rxd,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [2:0]       cfg_par,
    output logic             rx_valid,
    output logic [DW-1:0]    rx_data,
    output logic             rx_ferr,
    output logic             rx_perr,
    output logic             rx_brk,
    output logic             brk_chg
);
    localparam int CNT_W    = $clog2(OSR);
    localparam int HALF     = OSR / 2;
    localparam int IDX_W    = $clog2(DW);
    localparam int NB_W     = $clog2(DW + 1);
    localparam int MIN_BITS = DW - (1 << LEN_W) + 1;

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DW-1:0]     shreg_q;
    logic              pbit_q;
    logic              rx_s;
    logic [NB_W-1:0]   nbits;
    logic              at_mid, at_full, last_bit, has_slot;
    logic              all_zero, is_break, par_flag;

    uart_brk_rx_sync #(
        .STAGES  (SYNC_STAGES),
        .IDLE_LVL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rxd),
        .q    (rx_s)
    );

    uart_brk_rx_parchk #(
        .DW  (DW),
        .NB_W(NB_W)
    ) u_par (
        .data (shreg_q),
        .nbits(nbits),
        .mode (cfg_par),
        .pbit (pbit_q),
        .flag (par_flag)
    );

    assign nbits    = NB_W'(cfg_len) + NB_W'(MIN_BITS);
    assign at_mid   = tick16 && (cnt_q == CNT_W'(HALF - 1));
    assign at_full  = tick16 && (cnt_q == CNT_W'(OSR - 1));
    assign last_bit = (NB_W'(idx_q) == nbits - NB_W'(1));
    assign has_slot = par_slot(cfg_par);
    assign all_zero = (shreg_q == '0) && !pbit_q;
    assign is_break = (state_q == ST_STOP) && at_full && !rx_s && all_zero;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick16 && !rx_s) state_d = ST_START;
            ST_START: if (at_mid) state_d = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:  if (at_full && last_bit) state_d = has_slot ? ST_PAR : ST_STOP;
            ST_PAR:   if (at_full) state_d = ST_STOP;
            ST_STOP:  if (at_full) state_d = is_break ? ST_BRK : ST_IDLE;
            ST_BRK:   if (at_mid && rx_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and receive datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            pbit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (tick16) begin
                if (state_q == ST_BRK) begin
                    cnt_q <= rx_s ? cnt_q + CNT_W'(1) : '0;
                end else begin
                    cnt_q <= (cnt_q == CNT_W'(OSR - 1)) ? '0 : cnt_q + CNT_W'(1);
                end
            end
            if (state_q == ST_START && state_d == ST_DATA) begin
                shreg_q <= '0;
                idx_q   <= '0;
                pbit_q  <= 1'b0;
            end else if (state_q == ST_DATA && at_full) begin
                shreg_q[idx_q] <= rx_s;
                idx_q          <= idx_q + IDX_W'(1);
            end else if (state_q == ST_PAR && at_full) begin
                pbit_q <= rx_s;
            end
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_ferr  <= 1'b0;
            rx_perr  <= 1'b0;
            rx_brk   <= 1'b0;
            brk_chg  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_ferr  <= 1'b0;
            rx_perr  <= 1'b0;
            rx_brk   <= 1'b0;
            brk_chg  <= 1'b0;
            if (state_q == ST_STOP && at_full) begin
                rx_valid <= 1'b1;
                if (is_break) begin
                    rx_brk  <= 1'b1;
                    brk_chg <= 1'b1;
                end else begin
                    rx_data <= shreg_q;
                    rx_ferr <= !rx_s;
                    rx_perr <= par_flag;
                end
            end else if (state_q == ST_BRK && state_d == ST_IDLE) begin
                brk_chg <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_brk_rx_chk.sv
`timescale 1ns/1ps
module uart_brk_rx_chk #(
    parameter int DW       = 8,
    parameter int LEN_W    = 2,
    parameter int MIN_BITS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] cfg_len,
    input logic             rx_valid,
    input logic [DW-1:0]    rx_data,
    input logic             rx_ferr,
    input logic             rx_perr,
    input logic             rx_brk,
    input logic             brk_chg
);
    logic in_brk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_brk <= 1'b0;
        end else if (rx_valid && rx_brk) begin
            in_brk <= 1'b1;
        end else if (brk_chg && in_brk) begin
            in_brk <= 1'b0;
        end
    end

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_flags_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> !(rx_ferr || rx_perr || rx_brk));

    assert_len_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> (int'(cfg_len) + MIN_BITS)) == '0));

    assert_brk_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_data == '0 && !rx_ferr && !rx_perr));

    assert_brk_chg_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> brk_chg);

    assert_chg_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_chg |=> !brk_chg);

    assert_brk_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_brk |-> !rx_valid);
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_len (cfg_len),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_ferr (rx_ferr),
    .rx_perr (rx_perr),
    .rx_brk  (rx_brk),
    .brk_chg (brk_chg)
);

// File: tb/tb_uart_brk_rx.sv
`timescale 1ns/1ps
module tb_uart_brk_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd0;
    logic [2:0] cfg_par = 3'd0;
    logic       rx_valid, rx_ferr, rx_perr, rx_brk, brk_chg;
    logic [7:0] rx_data;

    int tdiv = 1;
    int tk_c = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int ncap = 0;
    int nchg = 0;
    logic [7:0] cap_d [0:15];
    logic       cap_f [0:15];
    logic       cap_p [0:15];
    logic       cap_b [0:15];

    uart_brk_rx dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
        .rx_perr(rx_perr), .rx_brk(rx_brk), .brk_chg(brk_chg)
    );

    always #2.5 clk = ~clk;

    // Oversampling enable: one pulse every tdiv clocks.
    initial begin
        forever begin
            @(posedge clk);
            if (tk_c >= tdiv - 1) begin
                tk_c = 0;
                tick16 <= 1'b1;
            end else begin
                tk_c++;
                tick16 <= 1'b0;
            end
        end
    end

    // Output capture, away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                if (ncap < 16) begin
                    cap_d[ncap] = rx_data;
                    cap_f[ncap] = rx_ferr;
                    cap_p[ncap] = rx_perr;
                    cap_b[ncap] = rx_brk;
                end
                ncap++;
            end
            if (brk_chg) nchg++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_cap();
        ncap = 0;
        nchg = 0;
    endtask

    task automatic hold(input logic b, input int ticks);
        rxd <= b;
        repeat (ticks * tdiv) @(posedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input logic slot,
                              input logic pb, input logic stopv);
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (slot) hold(pb, 16);
        hold(stopv, 16);
        hold(1'b1, 32);
    endtask

    function automatic logic good_par(input logic [7:0] d, input int mode);
        logic x;
        x = ^d;
        case (mode)
            1: return x;
            2: return ~x;
            3: return 1'b0;
            4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // One frame, checked against values computed here.
    task automatic run_one(input int len, input int mode, input logic [7:0] raw, input logic flip);
        int nb;
        logic [7:0] d;
        logic slot, pb, exp_pe;
        nb = len + 5;
        d = raw & 8'((1 << nb) - 1);
        slot = (mode >= 1 && mode <= 5);
        if (mode == 5) begin
            pb = flip;
            exp_pe = flip;
        end else begin
            pb = good_par(d, mode) ^ flip;
            exp_pe = slot && flip;
        end
        cfg_len = 2'(len);
        cfg_par = 3'(mode);
        clear_cap();
        send_frame(d, nb, slot, pb, 1'b1);
        @(negedge clk);
        check("R3 count", ncap, 1);
        check("R3 data", int'(cap_d[0]), int'(d));
        check(mode == 5 ? "R5 wake bit" : "R4 parity flag", int'(cap_p[0]), int'(exp_pe));
        check("R6 no ferr", int'(cap_f[0]), 0);
        check("R7 no brk", int'(cap_b[0]), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", int'(rx_valid), 0);
        check("R1 chg in reset", int'(brk_chg), 0);
        check("R1 data in reset", int'(rx_data), 0);
        check("R1 flags in reset", int'({rx_ferr, rx_perr, rx_brk}), 0);
        @(posedge clk);
        rst_n <= 1'b1;
        clear_cap();
        repeat (200) @(posedge clk);
        @(negedge clk);
        check("R1 idle no char", ncap, 0);

        // Exhaustive values at 5 bits, no parity.
        for (int v = 0; v < 32; v++) run_one(0, 0, 8'(v), 1'b0);

        // Every length and mode, correct and flipped parity bit.
        for (int len = 0; len < 4; len++) begin
            for (int mode = 0; mode < 6; mode++) begin
                for (int k = 0; k < 8; k++) begin
                    run_one(len, mode, 8'(k * 37 + len * 11 + 13),
                            (mode == 5) ? k[0] : (k == 3 || k == 6));
                end
            end
        end

        // R12: slower tick, same results.
        tdiv = 2;
        for (int k = 0; k < 6; k++) run_one(3, 1, 8'(k * 53 + 7), k[1]);
        tdiv = 1;

        // R2: short low pulse is not a start bit.
        clear_cap();
        hold(1'b0, 4);
        hold(1'b1, 48);
        @(negedge clk);
        check("R2 false start", ncap, 0);

        // R6: framing error with nonzero data.
        cfg_len = 2'd3;
        cfg_par = 3'd0;
        clear_cap();
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R6 count", ncap, 1);
        check("R6 ferr", int'(cap_f[0]), 1);
        check("R6 data", int'(cap_d[0]), 'h5A);
        check("R6 brk", int'(cap_b[0]), 0);

        // R7: zero data but parity bit 1 is not a break.
        cfg_par = 3'd2;
        clear_cap();
        send_frame(8'h00, 8, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check("R7 parity one count", ncap, 1);
        check("R7 parity one ferr", int'(cap_f[0]), 1);
        check("R7 parity one brk", int'(cap_b[0]), 0);
        check("R9 no chg", nchg, 0);

        // R7/R8/R9: long break at slow tick, with a glitch.
        tdiv = 3;
        cfg_par = 3'd1;
        clear_cap();
        hold(1'b0, 40 * 16);
        @(negedge clk);
        check("R7 break count", ncap, 1);
        check("R7 break data", int'(cap_d[0]), 0);
        check("R7 break flag", int'(cap_b[0]), 1);
        check("R7 break ferr", int'(cap_f[0]), 0);
        check("R9 start pulse", nchg, 1);
        hold(1'b1, 4);
        hold(1'b0, 32);
        @(negedge clk);
        check("R8 glitch no char", ncap, 1);
        check("R8 glitch no end", nchg, 1);
        hold(1'b1, 48);
        @(negedge clk);
        check("R9 end pulse", nchg, 2);
        check("R8 no char at end", ncap, 1);
        clear_cap();
        send_frame(8'hA5, 8, 1'b1, good_par(8'hA5, 1), 1'b1);
        @(negedge clk);
        check("R8 resume count", ncap, 1);
        check("R8 resume data", int'(cap_d[0]), 'hA5);
        tdiv = 1;

        // R10: break starting mid-character, long enough.
        cfg_par = 3'd0;
        clear_cap();
        hold(1'b0, 16);
        hold(1'b1, 48);
        hold(1'b0, 20 * 16);
        hold(1'b1, 48);
        @(negedge clk);
        check("R10 count", ncap, 2);
        check("R10 first data", int'(cap_d[0]), 7);
        check("R10 first ferr", int'(cap_f[0]), 1);
        check("R10 first brk", int'(cap_b[0]), 0);
        check("R10 second brk", int'(cap_b[1]), 1);
        check("R10 chg", nchg, 2);

        // R10: mid-character low that ends too early is no break.
        clear_cap();
        hold(1'b0, 16);
        hold(1'b1, 48);
        hold(1'b0, 6 * 16);
        hold(1'b1, 64);
        @(negedge clk);
        check("R10 short count", ncap, 1);
        check("R10 short ferr", int'(cap_f[0]), 1);
        check("R10 short brk", int'(cap_b[0]), 0);
        check("R10 short chg", nchg, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule